// File: doc/BRIEF.md
# Debug-Port Flash Lock Checker

This block decides, one request at a time, whether an access to a 64 KB program memory may go ahead. Each request carries an access type (read, write or erase), a 16-bit address, a flag that marks the scratchpad sector, and a flag that tells a debug-port request from a software request. Two lock bytes come in as register inputs. One byte guards reads and the other guards writes and erases. Each bit of a lock byte covers one 8 KB block, and a bit value of 0 marks the block as locked.

Debug-port requests are checked against the lock bytes. Software requests skip the lock bytes, but they follow two other rules. A software write needs its write-enable bit. A software erase that lands in the sector holding the lock bytes is refused. The grant decision and the data-substitute flag come out combinationally. A registered copy of both, and a one-cycle error pulse for a refused lock-sector erase, appear one clock after the request.

Top module: `flash_lock_chk`

## Requirements
- R1: A valid debug-port read (acc_type_i = 0) of the main array is granted exactly when bit addr_i[15:13] of rd_lock_i is 1.
- R2: A valid debug-port write (acc_type_i = 1) or erase (acc_type_i = 2) of the main array is granted exactly when bit addr_i[15:13] of wr_lock_i is 1.
- R3: data_sub_o is 1 exactly when a valid debug-port read is denied. In every other case it is 0.
- R4: When scratch_i is 1, a debug-port read is denied only if rd_lock_i is 8'h00, and a debug-port write or erase is denied only if wr_lock_i is 8'h00. Other lock patterns have no effect on the scratchpad.
- R5: Software requests (dbg_src_i = 0) ignore both lock bytes. A software read is always granted. A software write is granted exactly when sw_wen_i is 1.
- R6: A software erase of the main array whose address lies in 0xFC00 to 0xFDFF is denied, and erase_err_o is 1 for the cycle after that request. A software erase outside that range, or of the scratchpad, is granted and gives no error. A software write into that range is still granted when sw_wen_i is 1.
- R7: grant_q_o and data_sub_q_o equal grant_o and data_sub_o of the previous cycle. All registered outputs are 0 during reset.
- R8: When req_vld_i is 0, or when acc_type_i = 3 (reserved), grant_o, data_sub_o and the error pulse stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_vld_i | input | 1 | Request valid |
| acc_type_i | input | 2 | 0 read, 1 write, 2 erase, 3 reserved |
| addr_i | input | 16 | Byte address |
| scratch_i | input | 1 | Request targets the scratchpad sector |
| dbg_src_i | input | 1 | 1 debug port, 0 software |
| sw_wen_i | input | 1 | Software write-enable control bit |
| rd_lock_i | input | 8 | Read lock byte, 0 = locked |
| wr_lock_i | input | 8 | Write/erase lock byte, 0 = locked |
| grant_o | output | 1 | Combinational grant |
| data_sub_o | output | 1 | Combinational data-substitute flag |
| grant_q_o | output | 1 | Registered grant |
| data_sub_q_o | output | 1 | Registered data-substitute flag |
| erase_err_o | output | 1 | Registered refused lock-sector erase pulse |

## Verification
The bench sweeps every access type and both sources, with the scratchpad flag on and off, the write-enable bit on and off, and the valid bit on and off. It drives these against twelve addresses: one inside each 8 KB block, plus the two edges of the lock sector and the addresses just outside them. Six lock patterns are used. The all-zero and all-one bytes show the scratchpad's all-or-nothing rule. The single-bit and mixed patterns show whether the right bit is selected, and they tell the read byte apart from the write byte. The lock-sector edge addresses check that erase refusal starts and stops at exactly the right bytes.

// File: rtl/flash_lock_pkg.sv
package flash_lock_pkg;
  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_ER  = 2'd2,
    ACC_RSV = 2'd3
  } acc_e;

  typedef struct packed {
    logic grant;
    logic sub;
    logic err;
  } lock_resp_t;
endpackage

// File: rtl/flash_lock_sel.sv
module flash_lock_sel #(
  parameter int ADDR_W = 16,
  parameter int BLK_W  = 3
) (
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic                   scratch_i,
  input  logic [(1<<BLK_W)-1:0]  lock_i,
  output logic                   open_o
);
  localparam int NUM_BLK = 1 << BLK_W;

  logic [BLK_W-1:0]   blk_idx;
  logic [NUM_BLK-1:0] hit;
  logic               blk_open;

  assign blk_idx = addr_i[ADDR_W-1 -: BLK_W];

  // one-hot block decode, AND-OR against lock bits
  for (genvar g = 0; g < NUM_BLK; g++) begin : g_dec
    assign hit[g] = (blk_idx == BLK_W'(g)) & lock_i[g];
  end

  assign blk_open = |hit;
  // scratchpad locked only when every block bit is cleared
  assign open_o   = scratch_i ? (|lock_i) : blk_open;
endmodule

// File: rtl/flash_lock_sec.sv
module flash_lock_sec #(
  parameter int              ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SEC_LO = 16'hFC00,
  parameter logic [ADDR_W-1:0] SEC_HI = 16'hFDFF
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              in_sec_o
);
  assign in_sec_o = (addr_i >= SEC_LO) && (addr_i <= SEC_HI);
endmodule

// File: rtl/flash_lock_policy.sv
module flash_lock_policy
  import flash_lock_pkg::*;
(
  input  logic       req_vld_i,
  input  acc_e       acc_i,
  input  logic       dbg_src_i,
  input  logic       scratch_i,
  input  logic       sw_wen_i,
  input  logic       rd_open_i,
  input  logic       wr_open_i,
  input  logic       in_sec_i,
  output lock_resp_t resp_o
);
  always_comb begin
    resp_o = '0;
    if (req_vld_i) begin
      unique case (acc_i)
        ACC_RD: begin
          resp_o.grant = dbg_src_i ? rd_open_i : 1'b1;
          resp_o.sub   = dbg_src_i & ~rd_open_i;
        end
        ACC_WR: resp_o.grant = dbg_src_i ? wr_open_i : sw_wen_i;
        ACC_ER: begin
          if (dbg_src_i) begin
            resp_o.grant = wr_open_i;
          end else begin
            resp_o.err   = ~scratch_i & in_sec_i;
            resp_o.grant = ~resp_o.err;
          end
        end
        default: resp_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/flash_lock_resp_reg.sv
module flash_lock_resp_reg
  import flash_lock_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  lock_resp_t resp_i,
  output lock_resp_t resp_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) resp_q_o <= '0;
    else         resp_q_o <= resp_i;
  end
endmodule

// File: rtl/flash_lock_chk.sv
module flash_lock_chk
  import flash_lock_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BLK_W  = 3,
  parameter logic [ADDR_W-1:0] SEC_LO = 16'hFC00,
  parameter logic [ADDR_W-1:0] SEC_HI = 16'hFDFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_vld_i,
  input  logic [1:0]        acc_type_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              scratch_i,
  input  logic              dbg_src_i,
  input  logic              sw_wen_i,
  input  logic [(1<<BLK_W)-1:0] rd_lock_i,
  input  logic [(1<<BLK_W)-1:0] wr_lock_i,
  output logic              grant_o,
  output logic              data_sub_o,
  output logic              grant_q_o,
  output logic              data_sub_q_o,
  output logic              erase_err_o
);
  localparam int NUM_BLK = 1 << BLK_W;

  logic       rd_open, wr_open, in_sec;
  acc_e       acc;
  lock_resp_t resp, resp_q;

  assign acc = acc_e'(acc_type_i);

  flash_lock_sel #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_rd_sel (
    .addr_i(addr_i), .scratch_i(scratch_i), .lock_i(rd_lock_i), .open_o(rd_open)
  );

  flash_lock_sel #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_wr_sel (
    .addr_i(addr_i), .scratch_i(scratch_i), .lock_i(wr_lock_i), .open_o(wr_open)
  );

  flash_lock_sec #(.ADDR_W(ADDR_W), .SEC_LO(SEC_LO), .SEC_HI(SEC_HI)) u_sec (
    .addr_i(addr_i), .in_sec_o(in_sec)
  );

  flash_lock_policy u_pol (
    .req_vld_i(req_vld_i), .acc_i(acc), .dbg_src_i(dbg_src_i),
    .scratch_i(scratch_i), .sw_wen_i(sw_wen_i), .rd_open_i(rd_open),
    .wr_open_i(wr_open), .in_sec_i(in_sec), .resp_o(resp)
  );

  flash_lock_resp_reg u_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .resp_i(resp), .resp_q_o(resp_q)
  );

  assign grant_o      = resp.grant;
  assign data_sub_o   = resp.sub;
  assign grant_q_o    = resp_q.grant;
  assign data_sub_q_o = resp_q.sub;
  assign erase_err_o  = resp_q.err;

  logic [BLK_W-1:0] a_blk;
  assign a_blk = addr_i[ADDR_W-1 -: BLK_W];

  AST_DBG_RD_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_vld_i && dbg_src_i && !scratch_i && acc_type_i == 2'd0 && !rd_lock_i[a_blk])
    |-> (!grant_o && data_sub_o)); // R1
  AST_DBG_WR_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_vld_i && dbg_src_i && !scratch_i && (acc_type_i == 2'd1 || acc_type_i == 2'd2)
     && !wr_lock_i[a_blk]) |-> !grant_o); // R2
  AST_SUB_IMPL_DENY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_sub_q_o |-> !grant_q_o); // R3
  AST_SCR_PARTIAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_vld_i && dbg_src_i && scratch_i && acc_type_i == 2'd0 && rd_lock_i != '0)
    |-> grant_o); // R4
  AST_SW_RD_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_vld_i && !dbg_src_i && acc_type_i == 2'd0) |-> grant_o); // R5
  AST_ERR_DENIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_err_o |-> (!grant_q_o && $past(req_vld_i) && !$past(dbg_src_i))); // R6
  AST_Q_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_q_o |-> $past(req_vld_i)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_vld_i || acc_type_i == 2'd3) |-> (!grant_o && !data_sub_o)); // R8

  initial begin
    AST_BLK_FITS: assert (NUM_BLK <= (1 << ADDR_W)); // R1
  end
endmodule

// File: tb/tb_flash_lock_chk.sv
module tb_flash_lock_chk;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_vld_i = 1'b0;
  logic [1:0]  acc_type_i = '0;
  logic [15:0] addr_i = '0;
  logic        scratch_i = 1'b0;
  logic        dbg_src_i = 1'b0;
  logic        sw_wen_i = 1'b0;
  logic [7:0]  rd_lock_i = '0;
  logic [7:0]  wr_lock_i = '0;
  logic grant_o, data_sub_o, grant_q_o, data_sub_q_o, erase_err_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  flash_lock_chk dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_vld_i(req_vld_i), .acc_type_i(acc_type_i),
    .addr_i(addr_i), .scratch_i(scratch_i), .dbg_src_i(dbg_src_i), .sw_wen_i(sw_wen_i),
    .rd_lock_i(rd_lock_i), .wr_lock_i(wr_lock_i), .grant_o(grant_o),
    .data_sub_o(data_sub_o), .grant_q_o(grant_q_o), .data_sub_q_o(data_sub_q_o),
    .erase_err_o(erase_err_o)
  );

  task automatic chk(input string req, input logic got, input logic exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (src=%b acc=%0d scr=%b addr=%h wen=%b rd=%h wr=%h vld=%b)",
               req, got, exp, dbg_src_i, acc_type_i, scratch_i, addr_i, sw_wen_i,
               rd_lock_i, wr_lock_i, req_vld_i);
    end
  endtask

  function automatic logic [7:0] pat(input int i);
    case (i)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'hA5;
      3: return 8'h01;
      4: return 8'h80;
      default: return 8'h7E;
    endcase
  endfunction

  function automatic logic [15:0] addr_at(input int i);
    case (i)
      8:  return 16'hFBFF;
      9:  return 16'hFC00;
      10: return 16'hFDFF;
      11: return 16'hFE00;
      default: return 16'((i * 8192) + (i * 37) + 3);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic eg, es, ee, open;
    string tg;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R7 reset grant_q", grant_q_o, 1'b0);
    chk("R7 reset sub_q", data_sub_q_o, 1'b0);
    chk("R7 reset err", erase_err_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int v = 0; v < 2; v++)
    for (int s = 0; s < 2; s++)
    for (int a = 0; a < 4; a++)
    for (int sc = 0; sc < 2; sc++)
    for (int w = 0; w < 2; w++)
    for (int ai = 0; ai < 12; ai++)
    for (int p = 0; p < 6; p++) begin
      @(negedge clk_i);
      req_vld_i  = v[0];
      dbg_src_i  = s[0];
      acc_type_i = a[1:0];
      scratch_i  = sc[0];
      sw_wen_i   = w[0];
      addr_i     = addr_at(ai);
      rd_lock_i  = pat(p);
      wr_lock_i  = {pat(p)[3:0], pat(p)[7:4]};
      eg = 1'b0; es = 1'b0; ee = 1'b0;
      tg = "R8";
      if (v == 1 && a != 3) begin
        if (s == 1) begin
          if (a == 0) begin
            open = (sc == 1) ? (rd_lock_i != 8'h00) : rd_lock_i[addr_i[15:13]];
            eg = open; es = !open;
            tg = (sc == 1) ? "R4" : "R1";
          end else begin
            open = (sc == 1) ? (wr_lock_i != 8'h00) : wr_lock_i[addr_i[15:13]];
            eg = open;
            tg = (sc == 1) ? "R4" : "R2";
          end
        end else begin
          if (a == 0) begin eg = 1'b1; tg = "R5"; end
          else if (a == 1) begin eg = w[0]; tg = "R5"; end
          else begin
            ee = (sc == 0) && (addr_i >= 16'hFC00) && (addr_i <= 16'hFDFF);
            eg = !ee;
            tg = "R6";
          end
        end
      end
      #1;
      chk({tg, " grant"}, grant_o, eg);
      chk("R3 data_sub", data_sub_o, es);
      @(posedge clk_i);
      #1;
      chk("R7 grant_q", grant_q_o, eg);
      chk("R7 data_sub_q", data_sub_q_o, es);
      chk("R6 erase_err", erase_err_o, ee);
    end

    // pulse lasts one cycle once the request drops
    @(negedge clk_i);
    req_vld_i = 1'b1; dbg_src_i = 1'b0; acc_type_i = 2'd2; scratch_i = 1'b0;
    addr_i = 16'hFD00;
    @(negedge clk_i);
    chk("R6 pulse set", erase_err_o, 1'b1);
    req_vld_i = 1'b0;
    @(negedge clk_i);
    chk("R6 pulse clear", erase_err_o, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule